// File: doc/BRIEF.md
# Error-Correcting Instruction Word Store

This block holds instruction words for a command-processing engine in a small synchronous array and protects every stored word with a single-error-correct, double-error-detect code. Each 64-bit word is widened to 72 bits on its way into the array. On the way out, a single flipped bit is repaired and a pair of flipped bits is reported as uncorrectable. A word is addressed by a 32-bit instruction number and a 3-bit word number, so one instruction spans up to eight words. The low bits of the instruction number choose the array slot.

A coding enable lets the store act as a plain memory. A 2-bit injection control corrupts the check part of words as they are written, which lets diagnostics exercise both error paths without touching real data. Every repaired read raises a one-cycle single-error event and every uncorrectable read raises a one-cycle double-error event. The instruction and word numbers of the first faulty read are held until software clears the status.

Top module: `ibuf_secded`

## Requirements
- R1: A read request on `rd_req` returns the stored 64-bit word on `rd_data`, with `rd_valid` high, exactly one clock cycle after the request. With no request, `rd_valid` is low in the next cycle.
- R2: When `code_en` is 0 at write time and at read time, the word comes back exactly as written and neither event fires, even if the injection code is 11.
- R3: With `code_en` = 1 and injection code 00, reads return the written word and raise no event, for all-zero, all-one, alternating and walking-one patterns.
- R4: Injection codes 01 and 10 flip stored bit 0, which is the overall parity bit. A later read with coding on returns the original word and pulses `sbe_evt` for that one cycle.
- R5: Injection code 11 flips stored bits 0 and 1. A later read with coding on pulses `dbe_evt` and does not pulse `sbe_evt`.
- R6: `sbe_evt` and `dbe_evt` are never high in the same cycle.
- R7: The first error event after reset or after a clear sets the matching status flag (`sbe_seen` or `dbe_seen`). It also loads `err_inst` and `err_word` with the instruction and word numbers of the failing read. These values are valid from the cycle after the event.
- R8: While either status flag is set, later events set their own flag but leave `err_inst` and `err_word` unchanged. A one-cycle `err_clr` drops both flags, and the next event is then captured afresh.
- R9: After reset, `rd_valid`, both events, both flags, `err_inst` and `err_word` are all 0.
- R10: Words at different slot/word addresses, where the slot is `inst[SLOT_W-1:0]`, are stored independently. Writing one address does not change another.
- R11: An error event in the same cycle as `err_clr` is captured as a new first error: its flag is set and its location is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_en | input | 1 | 1 selects encode and check; 0 stores and returns raw data |
| inj_sel | input | 2 | Error injection code applied at write time: 00 none, 01/10 one bit, 11 two bits |
| wr_req | input | 1 | Write strobe |
| wr_inst | input | 32 | Instruction number of the write |
| wr_word | input | 3 | Word number within the instruction for the write |
| wr_data | input | 64 | Word to store |
| rd_req | input | 1 | Read strobe |
| rd_inst | input | 32 | Instruction number of the read |
| rd_word | input | 3 | Word number within the instruction for the read |
| err_clr | input | 1 | Clears both status flags |
| rd_valid | output | 1 | Read data is present this cycle |
| rd_data | output | 64 | Corrected read word |
| sbe_evt | output | 1 | Single-bit error corrected on this read |
| dbe_evt | output | 1 | Uncorrectable error on this read |
| sbe_seen | output | 1 | Sticky single-error status |
| dbe_seen | output | 1 | Sticky double-error status |
| err_inst | output | 32 | Instruction number of the first captured error |
| err_word | output | 3 | Word number of the first captured error |

## Verification
The store is filled with zeros, ones, alternating and walking-one words spread across slots and word numbers. Reading them all back shows whether the codec and the address decode lose or mix bits. The same store is then exercised with each injection code: 01 and 10 must be repaired silently apart from the event, 11 must be flagged and never counted as repaired, and raw mode must hide injection completely. The capture path is driven with a second error while the first is still held, with a clear followed by a fresh error, and with an error landing in the same cycle as the clear. These cases separate first-error priority from clear priority.

// File: rtl/ibuf_ecc_pkg.sv
package ibuf_ecc_pkg;

    localparam int DATA_W = 64;
    localparam int CODE_W = 72;
    localparam int SYN_W  = 7;
    localparam int INST_W = 32;
    localparam int WORD_W = 3;

    typedef enum logic [1:0] {
        INJ_NONE  = 2'b00,
        INJ_ONE_A = 2'b01,
        INJ_ONE_B = 2'b10,
        INJ_TWO   = 2'b11
    } inj_e;

    // Position i (1..CODE_W-1) is a Hamming position; bit 0 holds overall parity.
    function automatic logic is_chk_pos(input int i);
        return (i & (i - 1)) == 0;
    endfunction

    function automatic logic [CODE_W-1:0] place_data(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        int j;
        c = '0;
        j = 0;
        for (int i = 1; i < CODE_W; i++) begin
            if (!is_chk_pos(i)) begin
                c[i] = d[j];
                j++;
            end
        end
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pick_data(input logic [CODE_W-1:0] c);
        logic [DATA_W-1:0] d;
        int j;
        d = '0;
        j = 0;
        for (int i = 1; i < CODE_W; i++) begin
            if (!is_chk_pos(i)) begin
                d[j] = c[i];
                j++;
            end
        end
        return d;
    endfunction

    function automatic logic [SYN_W-1:0] syndrome(input logic [CODE_W-1:0] c);
        logic [SYN_W-1:0] s;
        s = '0;
        for (int i = 1; i < CODE_W; i++) begin
            if (c[i]) s = s ^ SYN_W'(i);
        end
        return s;
    endfunction

    typedef struct packed {
        logic                valid;
        logic                chk;
        logic [INST_W-1:0]   inst;
        logic [WORD_W-1:0]   word;
        logic [CODE_W-1:0]   code;
    } rd_stage_t;

    typedef struct packed {
        logic                sbe;
        logic                dbe;
        logic [INST_W-1:0]   inst;
        logic [WORD_W-1:0]   word;
    } cap_state_t;

endpackage

// File: rtl/secded_encode.sv
module secded_encode
    import ibuf_ecc_pkg::*;
(
    input  logic              en,
    input  logic [1:0]        inj,
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] base;
    logic [CODE_W-1:0] hamm;
    logic [SYN_W-1:0]  syn;
    logic [CODE_W-1:0] flip;

    always_comb begin
        base = place_data(data);
        syn  = syndrome(base);
        hamm = base;
        for (int k = 0; k < SYN_W; k++) begin
            hamm[1 << k] = syn[k];
        end
        hamm[0] = ^hamm[CODE_W-1:1];

        flip = '0;
        unique case (inj_e'(inj))
            INJ_NONE:             flip = '0;
            INJ_ONE_A, INJ_ONE_B: flip[0] = 1'b1;
            INJ_TWO:              flip[1:0] = 2'b11;
            default:              flip = '0;
        endcase

        code = en ? (hamm ^ flip) : base;
    end

endmodule

// File: rtl/secded_decode.sv
module secded_decode
    import ibuf_ecc_pkg::*;
(
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] data,
    output logic              sbe,
    output logic              dbe
);

    logic [SYN_W-1:0]  syn;
    logic              par_bad;
    logic              in_range;
    logic [CODE_W-1:0] fixed;

    always_comb begin
        syn      = syndrome(code);
        par_bad  = ^code;
        in_range = syn < SYN_W'(CODE_W);
        fixed    = code;
        if (en && par_bad && in_range) begin
            fixed[syn] = ~code[syn];
        end
        data = pick_data(fixed);
        sbe  = en && par_bad && in_range;
        dbe  = en && ((!par_bad && syn != '0) || (par_bad && !in_range));
    end

endmodule

// File: rtl/err_capture.sv
module err_capture
    import ibuf_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sbe,
    input  logic              dbe,
    input  logic [INST_W-1:0] inst,
    input  logic [WORD_W-1:0] word,
    output logic              sbe_seen,
    output logic              dbe_seen,
    output logic [INST_W-1:0] loc_inst,
    output logic [WORD_W-1:0] loc_word
);

    cap_state_t cap_d, cap_q;
    logic       held;

    always_comb begin
        cap_d = cap_q;
        held  = (cap_q.sbe || cap_q.dbe) && !clr;
        if (clr) begin
            cap_d.sbe = 1'b0;
            cap_d.dbe = 1'b0;
        end
        if (sbe) cap_d.sbe = 1'b1;
        if (dbe) cap_d.dbe = 1'b1;
        if ((sbe || dbe) && !held) begin
            cap_d.inst = inst;
            cap_d.word = word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign sbe_seen = cap_q.sbe;
    assign dbe_seen = cap_q.dbe;
    assign loc_inst = cap_q.inst;
    assign loc_word = cap_q.word;

    assert_first_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sbe_seen && !dbe_seen && (sbe || dbe))
        |=> (loc_inst == $past(inst) && loc_word == $past(word) && (sbe_seen || dbe_seen)));

    assert_hold_location_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((sbe_seen || dbe_seen) && !clr) |=> ($stable(loc_inst) && $stable(loc_word)));

    assert_clear_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (sbe || dbe)) |=> (loc_inst == $past(inst)));

endmodule

// File: rtl/ibuf_secded.sv
module ibuf_secded
    import ibuf_ecc_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_en,
    input  logic [1:0]        inj_sel,
    input  logic              wr_req,
    input  logic [31:0]       wr_inst,
    input  logic [2:0]        wr_word,
    input  logic [63:0]       wr_data,
    input  logic              rd_req,
    input  logic [31:0]       rd_inst,
    input  logic [2:0]        rd_word,
    input  logic              err_clr,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              sbe_evt,
    output logic              dbe_evt,
    output logic              sbe_seen,
    output logic              dbe_seen,
    output logic [31:0]       err_inst,
    output logic [2:0]        err_word
);

    localparam int ADDR_W = SLOT_W + WORD_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [CODE_W-1:0] mem [DEPTH];
    logic [CODE_W-1:0] wr_code;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] dec_data;
    logic              dec_sbe;
    logic              dec_dbe;

    rd_stage_t rs_d, rs_q;

    assign wr_addr = {wr_inst[SLOT_W-1:0], wr_word};
    assign rd_addr = {rd_inst[SLOT_W-1:0], rd_word};

    secded_encode u_enc (
        .en   (code_en),
        .inj  (inj_sel),
        .data (wr_data),
        .code (wr_code)
    );

    always_ff @(posedge clk) begin
        if (wr_req) mem[wr_addr] <= wr_code;
    end

    always_comb begin
        rs_d       = rs_q;
        rs_d.valid = rd_req;
        if (rd_req) begin
            rs_d.chk  = code_en;
            rs_d.inst = rd_inst;
            rs_d.word = rd_word;
            rs_d.code = mem[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    secded_decode u_dec (
        .en   (rs_q.chk),
        .code (rs_q.code),
        .data (dec_data),
        .sbe  (dec_sbe),
        .dbe  (dec_dbe)
    );

    assign rd_valid = rs_q.valid;
    assign rd_data  = dec_data;
    assign sbe_evt  = rs_q.valid && dec_sbe;
    assign dbe_evt  = rs_q.valid && dec_dbe;

    err_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (err_clr),
        .sbe      (sbe_evt),
        .dbe      (dbe_evt),
        .inst     (rs_q.inst),
        .word     (rs_q.word),
        .sbe_seen (sbe_seen),
        .dbe_seen (dbe_seen),
        .loc_inst (err_inst),
        .loc_word (err_word)
    );

    assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    assert_idle_no_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    assert_raw_mode_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !code_en) |=> !(sbe_evt || dbe_evt));

    assert_events_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sbe_evt, dbe_evt}));

endmodule

// File: tb/tb_ibuf_secded.sv
`timescale 1ns/1ps
module tb_ibuf_secded;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_en = 1'b1;
    logic [1:0]  inj_sel = 2'b00;
    logic        wr_req = 1'b0;
    logic [31:0] wr_inst = '0;
    logic [2:0]  wr_word = '0;
    logic [63:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic [31:0] rd_inst = '0;
    logic [2:0]  rd_word = '0;
    logic        err_clr = 1'b0;
    logic        rd_valid, sbe_evt, dbe_evt, sbe_seen, dbe_seen;
    logic [63:0] rd_data;
    logic [31:0] err_inst;
    logic [2:0]  err_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ibuf_secded dut (
        .clk(clk), .rst_n(rst_n), .code_en(code_en), .inj_sel(inj_sel),
        .wr_req(wr_req), .wr_inst(wr_inst), .wr_word(wr_word), .wr_data(wr_data),
        .rd_req(rd_req), .rd_inst(rd_inst), .rd_word(rd_word), .err_clr(err_clr),
        .rd_valid(rd_valid), .rd_data(rd_data), .sbe_evt(sbe_evt), .dbe_evt(dbe_evt),
        .sbe_seen(sbe_seen), .dbe_seen(dbe_seen), .err_inst(err_inst), .err_word(err_word)
    );

    typedef struct {
        logic [63:0] data;
        logic        sbe;
        logic        dbe;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] m_data [64];
    logic [1:0]  m_inj  [64];
    logic        m_en   [64];

    function automatic logic [5:0] maddr(input logic [31:0] inst, input logic [2:0] word);
        return {inst[2:0], word};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] inst, input logic [2:0] word,
                      input logic [63:0] d, input logic [1:0] inj);
        wr_req = 1'b1; wr_inst = inst; wr_word = word; wr_data = d; inj_sel = inj;
        m_data[maddr(inst, word)] = d;
        m_inj[maddr(inst, word)]  = inj;
        m_en[maddr(inst, word)]   = code_en;
        @(negedge clk);
        wr_req = 1'b0; inj_sel = 2'b00;
    endtask

    task automatic rd(input logic [31:0] inst, input logic [2:0] word,
                      input string tag, input bit clr_at_result);
        exp_t e;
        logic [5:0] a;
        a = maddr(inst, word);
        e.data = m_data[a];
        e.sbe  = code_en && m_en[a] && (m_inj[a] == 2'b01 || m_inj[a] == 2'b10);
        e.dbe  = code_en && m_en[a] && (m_inj[a] == 2'b11);
        e.tag  = tag;
        sb.push_back(e);
        rd_req = 1'b1; rd_inst = inst; rd_word = word;
        @(negedge clk);
        rd_req = 1'b0; err_clr = clr_at_result;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1", "unexpected rd_valid", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rd_data == e.data, e.tag, "rd_data", rd_data, e.data);
                    check(sbe_evt == e.sbe && dbe_evt == e.dbe, e.tag, "events {sbe,dbe}",
                          {62'd0, sbe_evt, dbe_evt}, {62'd0, e.sbe, e.dbe});
                    check(!(sbe_evt && dbe_evt), "R6", "both events",
                          {62'd0, sbe_evt, dbe_evt}, 64'd0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_data[i] = '0; m_inj[i] = '0; m_en[i] = 1'b1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        check(!rd_valid && !sbe_evt && !dbe_evt, "R9", "rd_valid/events",
              {61'd0, rd_valid, sbe_evt, dbe_evt}, 64'd0);
        check(!sbe_seen && !dbe_seen, "R9", "flags", {62'd0, sbe_seen, dbe_seen}, 64'd0);
        check(err_inst == 0 && err_word == 0, "R9", "location",
              {29'd0, err_inst, err_word}, 64'd0);

        // R3 / R10: clean patterns across slots and words
        code_en = 1'b1;
        wr(32'h0, 3'd0, 64'h0, 2'b00);
        wr(32'h1, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00);
        wr(32'h2, 3'd3, 64'hAAAA_AAAA_AAAA_AAAA, 2'b00);
        wr(32'h3, 3'd4, 64'h5555_5555_5555_5555, 2'b00);
        for (int b = 0; b < 8; b++) begin
            wr(32'h4 + b, 3'(b), 64'h1 << (b * 8 + b), 2'b00);
        end
        rd(32'h0, 3'd0, "R3", 1'b0);
        rd(32'h1, 3'd7, "R3", 1'b0);
        rd(32'h2, 3'd3, "R3", 1'b0);
        rd(32'h3, 3'd4, "R3", 1'b0);
        for (int b = 0; b < 8; b++) begin
            rd(32'h4 + b, 3'(b), "R10", 1'b0);
        end
        rd(32'h1, 3'd7, "R1", 1'b0);
        check(!sbe_seen && !dbe_seen, "R3", "flags after clean reads",
              {62'd0, sbe_seen, dbe_seen}, 64'd0);

        // R2: raw mode hides injection
        code_en = 1'b0;
        wr(32'h5, 3'd1, 64'hDEAD_BEEF_0123_4567, 2'b11);
        rd(32'h5, 3'd1, "R2", 1'b0);
        check(!sbe_seen && !dbe_seen, "R2", "flags in raw mode",
              {62'd0, sbe_seen, dbe_seen}, 64'd0);

        // R4 / R7: single-bit injection, first capture
        code_en = 1'b1;
        wr(32'h0000_0108, 3'd5, 64'h0F0F_1234_5678_9ABC, 2'b01);
        wr(32'h0000_0209, 3'd2, 64'hCAFE_F00D_0000_FFFF, 2'b10);
        wr(32'h0000_030A, 3'd6, 64'h8000_0000_0000_0001, 2'b11);
        wr(32'h0000_040B, 3'd1, 64'h7777_8888_9999_AAAA, 2'b11);
        rd(32'h0000_0108, 3'd5, "R4", 1'b0);
        check(sbe_seen && !dbe_seen, "R7", "flags after first sbe",
              {62'd0, sbe_seen, dbe_seen}, 64'd2);
        check(err_inst == 32'h108 && err_word == 3'd5, "R7", "captured location",
              {29'd0, err_inst, err_word}, {29'd0, 32'h108, 3'd5});

        // R5 / R8: double-bit error while held
        rd(32'h0000_030A, 3'd6, "R5", 1'b0);
        check(sbe_seen && dbe_seen, "R8", "flags after second error",
              {62'd0, sbe_seen, dbe_seen}, 64'd3);
        check(err_inst == 32'h108 && err_word == 3'd5, "R8", "location held",
              {29'd0, err_inst, err_word}, {29'd0, 32'h108, 3'd5});

        // R8: clear then recapture
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check(!sbe_seen && !dbe_seen, "R8", "flags after clear",
              {62'd0, sbe_seen, dbe_seen}, 64'd0);
        rd(32'h0000_0209, 3'd2, "R4", 1'b0);
        check(err_inst == 32'h209 && err_word == 3'd2 && sbe_seen, "R8", "recaptured location",
              {28'd0, sbe_seen, err_inst, err_word}, {28'd0, 1'b1, 32'h209, 3'd2});

        // R11: error in the same cycle as clear
        rd(32'h0000_040B, 3'd1, "R5", 1'b1);
        check(dbe_seen && !sbe_seen, "R11", "flags after clear with error",
              {62'd0, sbe_seen, dbe_seen}, 64'd1);
        check(err_inst == 32'h40B && err_word == 3'd1, "R11", "location after clear with error",
              {29'd0, err_inst, err_word}, {29'd0, 32'h40B, 3'd1});

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R1", "outstanding reads", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule